// File: doc/BRIEF.md
# SPI Peripheral Status Flag and Interrupt Unit

This unit keeps the status and error flags of a FIFO-based SPI peripheral and turns them into one active-high, level-sensitive interrupt line. Event pulses from the data path set sticky flags: two service flags, two done flags, four core data errors and two serial-clock errors. Software clears a sticky flag by writing a one to its bit. Writing back a value that was just read therefore clears exactly the flags that were seen. Block-request, FIFO-full and FIFO-not-empty bits are live copies of status inputs. They appear in the same status word but keep no state of their own.

Software reaches six registers through a flat select-and-write port. Reads are combinational on `reg_sel`. A mask register can stop either service flag from raising the interrupt without stopping the flag itself. Each error flag has an enable at the same bit position. A disabled error is still recorded but does not interrupt. The block has no sequencing of its own. Every sticky bit is a two-state element (clear, set), and the interrupt is a pure combine of those bits.

Top module: `flag_irq_unit`

## Requirements
- R1: After reset every sticky flag, both mask bits and all error enables are zero, and `irq` is low.
- R2: Register select codes are 0 status, 1 service mask, 2 core error flags, 3 core error enables, 4 clock error flags, 5 clock error enables. Codes 6 and 7 read as zero. Bits not listed here read as zero.
- R3: Status bits 11 (input done), 10 (output done), 9 (input service) and 8 (output service) are set by `sticky_set[3:0]` in that order, are visible the cycle after the pulse, and hold until cleared.
- R4: A write with a one in a sticky bit position clears that flag. A zero leaves it unchanged. Writing back the value read clears every flag that was read as set.
- R5: When a set pulse and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R6: Status bits 13 (input block request), 12 (output block request), 7 (input full), 6 (output full), 5 (input not empty) and 4 (output not empty) follow their inputs in the same cycle, and writes do not change them.
- R7: Service mask bit 9 masks the input service flag and bit 8 masks the output service flag from the interrupt. A masked flag still sets and reads back.
- R8: Either done flag raises `irq` regardless of the mask.
- R9: Core error bits 5 (output overrun), 4 (input underrun), 3 (output underrun) and 2 (input overrun) are set by `core_err_set[3:0]` in that order. Clock error bits 1 (clock overrun) and 0 (clock underrun) are set by `clk_err_set[1:0]`. Error flags are recorded whatever their enables are, and they follow the same clear rules as R4 and R5.
- R10: `irq` is high exactly when an unmasked service flag, a done flag, or an error flag whose enable bit at the same position is set is present. It follows the flags combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | SEL_W | Register select for read and write |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data of the selected register |
| sticky_set | input | 4 | Set pulses: input done, output done, input service, output service |
| core_err_set | input | 4 | Set pulses: output overrun, input underrun, output underrun, input overrun |
| clk_err_set | input | 2 | Set pulses: clock overrun, clock underrun |
| in_blk_req | input | 1 | Live input block request |
| out_blk_req | input | 1 | Live output block request |
| in_full | input | 1 | Live input FIFO full |
| out_full | input | 1 | Live output FIFO full |
| in_nempty | input | 1 | Live input FIFO not empty |
| out_nempty | input | 1 | Live output FIFO not empty |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench builds the unit with its default parameters: a 32-bit data word and a 3-bit select. With four sticky flags, four core errors and two clock errors, every flag pattern can be crossed with every mask or enable setting in a short run. The sweeps cover all 64 combinations of live status inputs, every sticky pattern under all four mask settings, and every core and clock error pattern under every enable word. Each pattern is also cleared by writing back the value read, and the same-cycle set-against-clear collision is checked on each flag group.

// File: rtl/flag_irq_pkg.sv
package flag_irq_pkg;

    localparam int STICKY_N = 4;
    localparam int CORE_N   = 4;
    localparam int CLKE_N   = 2;

    // Field positions decoded by software
    localparam int STICKY_LSB = 8;   // bits 11..8
    localparam int CORE_LSB   = 2;   // bits 5..2
    localparam int CLKE_LSB   = 0;   // bits 1..0
    localparam int SVC_LSB    = 8;   // mask bits 9..8
    localparam int SVC_N      = 2;

    localparam int POS_IN_BLK   = 13;
    localparam int POS_OUT_BLK  = 12;
    localparam int POS_IN_FULL  = 7;
    localparam int POS_OUT_FULL = 6;
    localparam int POS_IN_NE    = 5;
    localparam int POS_OUT_NE   = 4;

    typedef enum logic [2:0] {
        SEL_STATUS   = 3'd0,
        SEL_SVC_MASK = 3'd1,
        SEL_CORE_FLG = 3'd2,
        SEL_CORE_EN  = 3'd3,
        SEL_CLKE_FLG = 3'd4,
        SEL_CLKE_EN  = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/w1c_flag_bank.sv
module w1c_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    // One two-state element per flag: CLEAR <-> SET, set has priority
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic state_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                state_q <= 1'b0;
            else if (set_i[b])
                state_q <= 1'b1;
            else if (clr_i[b])
                state_q <= 1'b0;
        end
        assign flags_o[b] = state_q;
    end
endmodule

// File: rtl/cfg_reg.sv
module cfg_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= '0;
        else if (we_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int CORE_W = 4,
    parameter int CLKE_W = 2
) (
    input  logic [3:0]        sticky_i,
    input  logic [1:0]        svc_mask_i,
    input  logic [CORE_W-1:0] core_flg_i,
    input  logic [CORE_W-1:0] core_en_i,
    input  logic [CLKE_W-1:0] clke_flg_i,
    input  logic [CLKE_W-1:0] clke_en_i,
    output logic              irq_o
);
    logic done_any, svc_any, core_any, clke_any;

    always_comb begin
        done_any = |sticky_i[3:2];
        svc_any  = |(sticky_i[1:0] & ~svc_mask_i);
        core_any = |(core_flg_i & core_en_i);
        clke_any = |(clke_flg_i & clke_en_i);
        irq_o    = done_any | svc_any | core_any | clke_any;
    end
endmodule

// File: rtl/flag_irq_unit.sv
module flag_irq_unit
    import flag_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [3:0]        sticky_set,
    input  logic [3:0]        core_err_set,
    input  logic [1:0]        clk_err_set,
    input  logic              in_blk_req,
    input  logic              out_blk_req,
    input  logic              in_full,
    input  logic              out_full,
    input  logic              in_nempty,
    input  logic              out_nempty,
    output logic              irq
);
    logic wr_status, wr_mask, wr_core_f, wr_core_e, wr_clke_f, wr_clke_e;

    logic [STICKY_N-1:0] sticky_q;
    logic [CORE_N-1:0]   core_q, core_en;
    logic [CLKE_N-1:0]   clke_q, clke_en;
    logic [SVC_N-1:0]    svc_mask;

    logic [STICKY_N-1:0] sticky_clr;
    logic [CORE_N-1:0]   core_clr;
    logic [CLKE_N-1:0]   clke_clr;

    always_comb begin
        wr_status = wr_en && (reg_sel == SEL_W'(SEL_STATUS));
        wr_mask   = wr_en && (reg_sel == SEL_W'(SEL_SVC_MASK));
        wr_core_f = wr_en && (reg_sel == SEL_W'(SEL_CORE_FLG));
        wr_core_e = wr_en && (reg_sel == SEL_W'(SEL_CORE_EN));
        wr_clke_f = wr_en && (reg_sel == SEL_W'(SEL_CLKE_FLG));
        wr_clke_e = wr_en && (reg_sel == SEL_W'(SEL_CLKE_EN));
        sticky_clr = wr_status ? wr_data[STICKY_LSB +: STICKY_N] : '0;
        core_clr   = wr_core_f ? wr_data[CORE_LSB +: CORE_N]     : '0;
        clke_clr   = wr_clke_f ? wr_data[CLKE_LSB +: CLKE_N]     : '0;
    end

    w1c_flag_bank #(.W(STICKY_N)) i_sticky (
        .clk(clk), .rst_n(rst_n), .set_i(sticky_set), .clr_i(sticky_clr), .flags_o(sticky_q)
    );
    w1c_flag_bank #(.W(CORE_N)) i_core (
        .clk(clk), .rst_n(rst_n), .set_i(core_err_set), .clr_i(core_clr), .flags_o(core_q)
    );
    w1c_flag_bank #(.W(CLKE_N)) i_clke (
        .clk(clk), .rst_n(rst_n), .set_i(clk_err_set), .clr_i(clke_clr), .flags_o(clke_q)
    );

    cfg_reg #(.W(SVC_N)) i_mask (
        .clk(clk), .rst_n(rst_n), .we_i(wr_mask), .d_i(wr_data[SVC_LSB +: SVC_N]), .q_o(svc_mask)
    );
    cfg_reg #(.W(CORE_N)) i_core_en (
        .clk(clk), .rst_n(rst_n), .we_i(wr_core_e), .d_i(wr_data[CORE_LSB +: CORE_N]), .q_o(core_en)
    );
    cfg_reg #(.W(CLKE_N)) i_clke_en (
        .clk(clk), .rst_n(rst_n), .we_i(wr_clke_e), .d_i(wr_data[CLKE_LSB +: CLKE_N]), .q_o(clke_en)
    );

    irq_combine #(.CORE_W(CORE_N), .CLKE_W(CLKE_N)) i_irq (
        .sticky_i(sticky_q), .svc_mask_i(svc_mask),
        .core_flg_i(core_q), .core_en_i(core_en),
        .clke_flg_i(clke_q), .clke_en_i(clke_en),
        .irq_o(irq)
    );

    always_comb begin
        rd_data = '0;
        case (reg_sel)
            SEL_W'(SEL_STATUS): begin
                rd_data[POS_IN_BLK]   = in_blk_req;
                rd_data[POS_OUT_BLK]  = out_blk_req;
                rd_data[POS_IN_FULL]  = in_full;
                rd_data[POS_OUT_FULL] = out_full;
                rd_data[POS_IN_NE]    = in_nempty;
                rd_data[POS_OUT_NE]   = out_nempty;
                rd_data[STICKY_LSB +: STICKY_N] = sticky_q;
            end
            SEL_W'(SEL_SVC_MASK): rd_data[SVC_LSB +: SVC_N]   = svc_mask;
            SEL_W'(SEL_CORE_FLG): rd_data[CORE_LSB +: CORE_N] = core_q;
            SEL_W'(SEL_CORE_EN):  rd_data[CORE_LSB +: CORE_N] = core_en;
            SEL_W'(SEL_CLKE_FLG): rd_data[CLKE_LSB +: CLKE_N] = clke_q;
            SEL_W'(SEL_CLKE_EN):  rd_data[CLKE_LSB +: CLKE_N] = clke_en;
            default:              rd_data = '0;
        endcase
    end
endmodule

// File: rtl/flag_irq_chk.sv
module flag_irq_chk #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [3:0]        sticky_set,
    input logic [3:0]        core_err_set,
    input logic [1:0]        clk_err_set,
    input logic              irq,
    input logic [3:0]        sticky_q,
    input logic [3:0]        core_q,
    input logic [1:0]        clke_q,
    input logic [1:0]        svc_mask,
    input logic [3:0]        core_en,
    input logic [1:0]        clke_en
);
    // R5: a set pulse always lands, even against a clear
    a_r5_sticky_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_set != 4'b0) |=> ((sticky_q & $past(sticky_set)) == $past(sticky_set)));

    // R9: clock errors recorded whatever their enable
    a_r9_clke_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_err_set != 2'b0) |=> ((clke_q & $past(clk_err_set)) == $past(clk_err_set)));

    // R4: write-one clears only the written bits of the core error flags
    a_r4_core_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_W'(2) && core_err_set == 4'b0)
        |=> (core_q == ($past(core_q) & ~$past(wr_data[5:2]))));

    // R3: sticky flags hold with no set and no status write
    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && reg_sel == SEL_W'(0)) && sticky_set == 4'b0) |=> $stable(sticky_q));

    // R10: the interrupt line needs a live source
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|sticky_q[3:2]) || (|(sticky_q[1:0] & ~svc_mask))
                 || (|(core_q & core_en)) || (|(clke_q & clke_en))));

    // R8: a done flag always drives the line
    a_r8_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|sticky_q[3:2]) |-> irq);
endmodule

bind flag_irq_unit flag_irq_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_flag_irq_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .sticky_set(sticky_set), .core_err_set(core_err_set), .clk_err_set(clk_err_set),
    .irq(irq), .sticky_q(sticky_q), .core_q(core_q), .clke_q(clke_q),
    .svc_mask(svc_mask), .core_en(core_en), .clke_en(clke_en)
);

// File: tb/test_flag_irq_unit.sv
module test_flag_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  sticky_set = '0;
    logic [3:0]  core_err_set = '0;
    logic [1:0]  clk_err_set = '0;
    logic [5:0]  live = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flag_irq_unit i_flag_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sticky_set(sticky_set),
        .core_err_set(core_err_set), .clk_err_set(clk_err_set),
        .in_blk_req(live[5]), .out_blk_req(live[4]), .in_full(live[3]),
        .out_full(live[2]), .in_nempty(live[1]), .out_nempty(live[0]), .irq(irq)
    );

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] live_word(input logic [5:0] l);
        return (32'(l[5]) << 13) | (32'(l[4]) << 12) | (32'(l[3]) << 7) |
               (32'(l[2]) << 6) | (32'(l[1]) << 5) | (32'(l[0]) << 4);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        exp_irq;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);

        // R2 unused selects and unused bits
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R2 mask bits only 9..8", v, 32'h0000_0300);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R2 core enable bits 5..2", v, 32'h0000_003C);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R2 clock enable bits 1..0", v, 32'h0000_0003);
        rd(3'd6, v); chk("R2 select 6 reads zero", v, 32'h0);
        rd(3'd7, v); chk("R2 select 7 reads zero", v, 32'h0);
        wr(3'd1, 32'h0); wr(3'd3, 32'h0); wr(3'd5, 32'h0);

        // R2/R6 live status sweep
        for (int l = 0; l < 64; l++) begin
            live = 6'(l);
            rd(3'd0, v); chk("R6 live bits follow inputs", v, live_word(6'(l)));
            wr(3'd0, 32'hFFFF_FFFF);
            rd(3'd0, v); chk("R6 live bits unaffected by write", v, live_word(6'(l)));
            chk("R6 live bits raise no irq", 32'(irq), 32'h0);
        end
        live = '0;

        // R3/R4/R7/R8/R10 sticky sweep under every mask
        for (int m = 0; m < 4; m++) begin
            wr(3'd1, 32'(m) << 8);
            for (int p = 1; p < 16; p++) begin
                sticky_set = 4'(p); cyc(); sticky_set = '0;
                rd(3'd0, v); chk("R3 sticky set", v, 32'(p) << 8);
                exp_irq = p[3] | p[2] | (p[1] & ~m[1]) | (p[0] & ~m[0]);
                chk("R7 R8 R10 irq vs mask", 32'(irq), 32'(exp_irq));
                cyc();
                rd(3'd0, v); chk("R3 sticky hold", v, 32'(p) << 8);
                wr(3'd0, v);
                rd(3'd0, v); chk("R4 write-back clears", v, 32'h0);
                chk("R10 irq low after clear", 32'(irq), 32'h0);
            end
        end
        wr(3'd1, 32'h0);

        // R4 partial clear, zeros leave flags alone
        sticky_set = 4'b1010; cyc(); sticky_set = '0;
        wr(3'd0, 32'h0000_0200);
        rd(3'd0, v); chk("R4 partial clear keeps bit 11", v, 32'h0000_0800);
        wr(3'd0, 32'h0000_0800);

        // R9/R10 core error sweep
        for (int e = 0; e < 16; e++) begin
            wr(3'd3, 32'(e) << 2);
            for (int p = 1; p < 16; p++) begin
                core_err_set = 4'(p); cyc(); core_err_set = '0;
                rd(3'd2, v); chk("R9 core flag recorded", v, 32'(p) << 2);
                chk("R9 R10 core irq vs enable", 32'(irq), 32'(|(p & e)));
                wr(3'd2, v);
                rd(3'd2, v); chk("R9 core write-back clears", v, 32'h0);
            end
        end
        wr(3'd3, 32'h0);

        // R9/R10 clock error sweep
        for (int e = 0; e < 4; e++) begin
            wr(3'd5, 32'(e));
            for (int p = 1; p < 4; p++) begin
                clk_err_set = 2'(p); cyc(); clk_err_set = '0;
                rd(3'd4, v); chk("R9 clock flag recorded", v, 32'(p));
                chk("R9 R10 clock irq vs enable", 32'(irq), 32'(|(p & e)));
                wr(3'd4, v);
                rd(3'd4, v); chk("R9 clock write-back clears", v, 32'h0);
            end
        end
        wr(3'd5, 32'h0);

        // R5 set beats clear in the same cycle
        sticky_set = 4'b0010; cyc(); sticky_set = '0;
        sticky_set = 4'b0010; reg_sel = 3'd0; wr_data = 32'h0000_0F00; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; sticky_set = '0;
        rd(3'd0, v); chk("R5 sticky set wins over clear", v, 32'h0000_0200);
        wr(3'd0, v);
        core_err_set = 4'b1000; reg_sel = 3'd2; wr_data = 32'h0000_003C; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; core_err_set = '0;
        rd(3'd2, v); chk("R5 core set wins over clear", v, 32'h0000_0020);
        wr(3'd2, v);
        clk_err_set = 2'b01; reg_sel = 3'd4; wr_data = 32'h0000_0003; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; clk_err_set = '0;
        rd(3'd4, v); chk("R5 clock set wins over clear", v, 32'h0000_0001);
        wr(3'd4, v);
        rd(3'd4, v); chk("R4 clock cleared afterwards", v, 32'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule